// File: doc/BRIEF.md
# Two-Slot Glitch-Free Processor Clock Selector

This block produces the clock for one processor domain from a set of free-running source clocks. A 16-bit control word holds two configuration slots. Each slot names a source clock and a divide ratio, and one bit of the word says which slot drives the output. A request carries a 4-bit frequency code. The block turns the code into a source and divider pair and writes that pair into the slot that is idle. It then flips the active-slot bit, so the output moves to the freshly written slot.

Each slot has its own source mux and divider. Each slot also has an output gate that runs in that slot's clock domain. The active-slot bit is passed into both domains through synchronisers. The outgoing gate closes first. The incoming gate opens only after the outgoing gate is seen closed. The output is therefore never cut into a short pulse. A busy flag covers the whole hand-over, and the block drops any request that arrives while busy is high. The control word is an output, so the slot contents can be seen.

Top module: `clksel_pingpong`

## Requirements
- R1: After a synchronous reset the control word is 0x3030: both slots hold source 3 with divider 0, the active-slot bit (bit 15) is 0 and the enable bit (bit 7) is 0. Busy is low and clk_out stays low until the first request.
- R2: An accepted request made while bit 15 is 0 writes the source into bits 14:12 and the divider into bits 11:8, then sets bit 15. Bits 6:0 are left unchanged.
- R3: An accepted request made while bit 15 is 1 writes the source into bits 6:4 and the divider into bits 3:0, then clears bit 15. Bits 14:8 are left unchanged.
- R4: Every accepted request sets bit 7 of the control word.
- R5: The frequency code maps to a (source, divider) pair as follows: code 1 gives (2,0), code 2 gives (0,1), code 4 gives (1,1), code 5 gives (0,3), code 6 gives (2,1), code 7 gives (2,3) and code 8 gives (4,0). Every other code gives (3,0).
- R6: Once busy falls, clk_out has the period of the selected source times (divider + 1). Source 4 is the undivided reference oscillator.
- R7: A request sampled while busy is low is accepted. Busy is high from the next clock edge until the new slot's gate is open and the old slot's gate is closed, as seen in the control clock domain.
- R8: A request sampled while busy is high leaves the control word unchanged, and it leaves the output frequency unchanged as well.
- R9: The two slot gates are never open at the same time. No high or low phase of clk_out is shorter than the shortest half-period among the source clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for request handling |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | NUM_SRC | Free-running source clocks, one bit per source index |
| req | input | 1 | Request strobe, sampled on clk |
| freq_code | input | 4 | Frequency code that goes with req |
| clk_out | output | 1 | Gated, divided processor clock |
| busy | output | 1 | High while a slot hand-over is in progress |
| ctl_word | output | 16 | Control word holding both slots, the enable bit and the active-slot bit |

## Verification
The control word and busy are registered on the clk edge that samples the request. The bench raises req on a falling edge and checks both values on the next falling edge. The end of busy depends on several clock domains, so its timing varies. The bench does not predict the exact cycle. It polls busy on every falling edge against a bounded timeout. Only after busy is low does the bench time two rising edges of clk_out and compare the period with the source period times (divider + 1). A monitor records the shortest clk_out phase across every switch, and that figure is checked at the end.

// File: rtl/clksel_pkg.sv
// Package clksel_pkg
// Purpose : control word layout, the slot configuration type, and the
//           mapping from frequency code to (source, divider).
// Assumes : the 16-bit word layout is fixed, because other logic decodes it.
package clksel_pkg;

    localparam int WORD_W     = 16;
    localparam int DIV_W      = 4;
    localparam int SRC_W      = 3;
    localparam int CODE_W     = 4;

    localparam int S0_DIV_LSB = 0;
    localparam int S0_SRC_LSB = 4;
    localparam int EN_BIT     = 7;
    localparam int S1_DIV_LSB = 8;
    localparam int S1_SRC_LSB = 12;
    localparam int SEL_BIT    = 15;

    localparam logic [WORD_W-1:0] RESET_WORD = 16'h3030;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } slot_cfg_t;

    // Translate a frequency code into the slot setting it requests.
    function automatic slot_cfg_t map_code(input logic [CODE_W-1:0] code);
        slot_cfg_t c;
        case (code)
            4'd1:    begin c.src = 3'd2; c.div = 4'd0; end
            4'd2:    begin c.src = 3'd0; c.div = 4'd1; end
            4'd4:    begin c.src = 3'd1; c.div = 4'd1; end
            4'd5:    begin c.src = 3'd0; c.div = 4'd3; end
            4'd6:    begin c.src = 3'd2; c.div = 4'd1; end
            4'd7:    begin c.src = 3'd2; c.div = 4'd3; end
            4'd8:    begin c.src = 3'd4; c.div = 4'd0; end
            default: begin c.src = 3'd3; c.div = 4'd0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/clksel_ctrl.sv
// Module  : clksel_ctrl
// Purpose : holds the control word in the clk domain. It writes each
//           accepted request into the idle slot, flips the active-slot bit,
//           and keeps busy high until both slot gates show the new state.
// Assumes : slot_gate comes from other clock domains and is synchronised here.
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [CODE_W-1:0]   freq_code,
    input  logic [1:0]          slot_gate,
    output logic [WORD_W-1:0]   ctl_word,
    output logic                busy
);

    localparam int LAST = SYNC_STAGES - 1;

    logic                  accept;
    logic [WORD_W-1:0]     word_nxt;
    slot_cfg_t             new_cfg;
    logic [1:0][SYNC_STAGES-1:0] gsync;
    logic [1:0]            gate_seen;
    logic                  settled;

    assign accept  = req & ~busy;
    assign new_cfg = map_code(freq_code);

    // Next control word: fill the idle slot, toggle the selector, set enable.
    always_comb begin
        word_nxt = ctl_word;
        if (ctl_word[SEL_BIT]) begin
            word_nxt[S0_SRC_LSB +: SRC_W] = new_cfg.src;
            word_nxt[S0_DIV_LSB +: DIV_W] = new_cfg.div;
            word_nxt[SEL_BIT]             = 1'b0;
        end else begin
            word_nxt[S1_SRC_LSB +: SRC_W] = new_cfg.src;
            word_nxt[S1_DIV_LSB +: DIV_W] = new_cfg.div;
            word_nxt[SEL_BIT]             = 1'b1;
        end
        word_nxt[EN_BIT] = 1'b1;
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_word <= RESET_WORD;
        else if (accept) ctl_word <= word_nxt;
    end

    // Bring both slot gate states into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) gsync <= '0;
        else begin
            for (int s = 0; s < 2; s++)
                gsync[s] <= {gsync[s][SYNC_STAGES-2:0], slot_gate[s]};
        end
    end

    assign gate_seen = {gsync[1][LAST], gsync[0][LAST]};
    assign settled   = ctl_word[SEL_BIT] ? (gate_seen == 2'b10)
                                         : (gate_seen == 2'b01);

    // Busy: set on accept, cleared once the hand-over is seen complete.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy <= 1'b0;
        else if (accept)  busy <= 1'b1;
        else if (settled) busy <= 1'b0;
    end

endmodule

// File: rtl/clksel_slot.sv
// Module  : clksel_slot
// Purpose : one configuration slot. It picks a source clock, divides it by
//           div+1, and gates the result with a gate that closes and opens
//           only while the slot clock is low.
// Assumes : cfg changes only while this slot's gate is closed. The source
//           clocks run during reset.
module clksel_slot
    import clksel_pkg::*;
#(
    parameter int NUM_SRC     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic               rst_n,
    input  slot_cfg_t          cfg,
    input  logic               want_on,
    output logic               gate_q,
    output logic               clk_gated
);

    logic                   raw_clk;
    logic [DIV_W-1:0]       cnt;
    logic [DIV_W-1:0]       cnt_nxt;
    logic [DIV_W:0]         half;
    logic                   div_q;
    logic                   slot_clk;
    logic [SYNC_STAGES-1:0] want_sync;

    // Source mux; an index outside the source range gives a quiet clock.
    always_comb begin
        raw_clk = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
            if (cfg.src == SRC_W'(i)) raw_clk = src_clk[i];
    end

    assign cnt_nxt = (cnt >= cfg.div) ? '0 : cnt + 1'b1;
    assign half    = ({1'b0, cfg.div} + 1'b1) >> 1;

    // Divider counter and output phase on the raw source clock.
    always_ff @(posedge raw_clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            div_q <= ({1'b0, cnt_nxt} < half);
        end
    end

    assign slot_clk = (cfg.div == '0) ? raw_clk : div_q;

    // Synchronise the gate request into the slot clock domain.
    always_ff @(posedge slot_clk) begin
        if (!rst_n) want_sync <= '0;
        else        want_sync <= {want_sync[SYNC_STAGES-2:0], want_on};
    end

    // Gate flop on the falling edge, so the gate only moves while the clock is low.
    always_ff @(negedge slot_clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= want_sync[SYNC_STAGES-1];
    end

    assign clk_gated = slot_clk & gate_q;

endmodule

// File: rtl/clksel_pingpong.sv
// Module  : clksel_pingpong
// Purpose : top level. It joins the control word logic to two slots and
//           ORs the two gated slot clocks into clk_out.
// Assumes : NUM_SRC source clocks run freely. SYNC_STAGES is at least 2.
module clksel_pingpong
    import clksel_pkg::*;
#(
    parameter int NUM_SRC     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_clk,
    input  logic                req,
    input  logic [CODE_W-1:0]   freq_code,
    output logic                clk_out,
    output logic                busy,
    output logic [WORD_W-1:0]   ctl_word
);

    slot_cfg_t  cfg   [2];
    logic [1:0] slot_gate;
    logic [1:0] want_on;
    logic [1:0] gated;

    clksel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .freq_code (freq_code),
        .slot_gate (slot_gate),
        .ctl_word  (ctl_word),
        .busy      (busy)
    );

    // Slot fields as laid out in the control word.
    assign cfg[0] = '{src: ctl_word[S0_SRC_LSB +: SRC_W], div: ctl_word[S0_DIV_LSB +: DIV_W]};
    assign cfg[1] = '{src: ctl_word[S1_SRC_LSB +: SRC_W], div: ctl_word[S1_DIV_LSB +: DIV_W]};

    for (genvar k = 0; k < 2; k++) begin : g_slot
        // A slot asks to open only when enabled, selected, and the other gate is closed.
        assign want_on[k] = ctl_word[EN_BIT] & (ctl_word[SEL_BIT] == 1'(k)) & ~slot_gate[1-k];

        clksel_slot #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_slot (
            .src_clk   (src_clk),
            .rst_n     (rst_n),
            .cfg       (cfg[k]),
            .want_on   (want_on[k]),
            .gate_q    (slot_gate[k]),
            .clk_gated (gated[k])
        );
    end

    assign clk_out = |gated;

endmodule

// File: rtl/clksel_pingpong_chk.sv
// Module  : clksel_pingpong_chk
// Purpose : assertions on the control word, busy, and the slot gates.
//           Attached to every clksel_pingpong by the bind below.
// Assumes : the control word layout from clksel_pkg.
module clksel_pingpong_chk
    import clksel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic [WORD_W-1:0] ctl_word,
    input logic [1:0]        slot_gate
);

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);                                                   // R7
    AST_WORD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctl_word));                                                // R8
    AST_SEL_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> (ctl_word[SEL_BIT] != $past(ctl_word[SEL_BIT])));        // R2
    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> ctl_word[EN_BIT]);                                       // R4
    AST_SLOT1_WRITE_KEEPS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && !ctl_word[SEL_BIT]) |=> (ctl_word[6:0] == $past(ctl_word[6:0])));   // R2
    AST_SLOT0_WRITE_KEEPS_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && ctl_word[SEL_BIT]) |=> (ctl_word[14:8] == $past(ctl_word[14:8])));  // R3
    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_gate[0] && slot_gate[1]));                                           // R9

endmodule

bind clksel_pingpong clksel_pingpong_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .busy      (busy),
    .ctl_word  (ctl_word),
    .slot_gate (slot_gate)
);

// File: tb/clksel_pingpong_tb_top.sv
`timescale 1ns/10ps
// Directed bench for clksel_pingpong. Each task drives one scenario and checks it.
module clksel_pingpong_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_clk = '0;
    logic        req = 1'b0;
    logic [3:0]  freq_code = '0;
    logic        clk_out;
    logic        busy;
    logic [15:0] ctl_word;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] model = 16'h3030;
    int          cyc = 0;

    real half_per [5] = '{2.0, 3.0, 5.0, 7.0, 10.0};

    clksel_pingpong dut_i (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .req(req),
        .freq_code(freq_code), .clk_out(clk_out), .busy(busy), .ctl_word(ctl_word)
    );

    always #2.5 clk = ~clk;
    always #2   src_clk[0] = ~src_clk[0];
    always #3   src_clk[1] = ~src_clk[1];
    always #5   src_clk[2] = ~src_clk[2];
    always #7   src_clk[3] = ~src_clk[3];
    always #10  src_clk[4] = ~src_clk[4];

    // Watchdog and cycle counter.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Glitch monitor: shortest clk_out phase once monitoring starts.
    bit  mon_on = 0;
    int  mon_edges = 0;
    real last_t = 0.0;
    real min_w = 1.0e9;
    int  out_rises = 0;
    always @(clk_out) begin
        if (clk_out) out_rises++;
        if (mon_on) begin
            if (mon_edges > 0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
            mon_edges++;
        end
        last_t = $realtime;
    end

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, exp);
        end
    endtask

    // Model of the requirement mapping table (R5).
    function automatic void code_pair(input logic [3:0] c, output int s, output int d);
        case (c)
            4'd1: begin s = 2; d = 0; end
            4'd2: begin s = 0; d = 1; end
            4'd4: begin s = 1; d = 1; end
            4'd5: begin s = 0; d = 3; end
            4'd6: begin s = 2; d = 1; end
            4'd7: begin s = 2; d = 3; end
            4'd8: begin s = 4; d = 0; end
            default: begin s = 3; d = 0; end
        endcase
    endfunction

    // Apply one accepted request to the bench's model of the control word (R2, R3, R4).
    function automatic void model_update(input logic [3:0] c);
        int s, d;
        code_pair(c, s, d);
        if (model[15]) begin
            model[6:4] = 3'(s); model[3:0] = 4'(d); model[15] = 1'b0;
        end else begin
            model[14:12] = 3'(s); model[11:8] = 4'(d); model[15] = 1'b1;
        end
        model[7] = 1'b1;
    endfunction

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(!busy, tag, "busy did not clear", busy, 0);
    endtask

    task automatic check_period(input logic [3:0] c, input string tag);
        int  s, d;
        real t0, t1, exp_p;
        code_pair(c, s, d);
        exp_p = 2.0 * half_per[s] * (d + 1);
        @(posedge clk_out); t0 = $realtime;
        @(posedge clk_out); t1 = $realtime;
        check((t1 - t0) > exp_p - 0.05 && (t1 - t0) < exp_p + 0.05, tag,
              "clk_out period x100ps", longint'((t1 - t0) * 10.0), longint'(exp_p * 10.0));
    endtask

    task automatic t_reset();
        int r0;
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctl_word == 16'h3030, "R1", "reset word", ctl_word, 16'h3030);
        check(busy == 1'b0, "R1", "reset busy", busy, 0);
        r0 = out_rises;
        repeat (40) @(negedge clk);
        check(out_rises == r0, "R1", "clk_out edges before request", out_rises - r0, 0);
    endtask

    // One accepted request: word and busy one cycle later, then the period (R2-R7).
    task automatic t_request(input logic [3:0] c);
        string tag;
        tag = model[15] ? "R3" : "R2";
        @(negedge clk); req = 1'b1; freq_code = c;
        @(negedge clk); req = 1'b0;
        model_update(c);
        check(ctl_word == model, tag, $sformatf("word after code %0d (R4 R5)", c), ctl_word, model);
        check(busy == 1'b1, "R7", "busy after accept", busy, 1);
        wait_idle("R7");
        check_period(c, "R6");
        if (!mon_on) mon_on = 1;
    endtask

    // A second request inside the busy window must be dropped (R8).
    task automatic t_ignore_busy();
        @(negedge clk); req = 1'b1; freq_code = 4'd7;
        @(negedge clk); freq_code = 4'd8;
        model_update(4'd7);
        @(negedge clk); req = 1'b0;
        check(ctl_word == model, "R8", "word after request while busy", ctl_word, model);
        check(busy == 1'b1, "R8", "still busy", busy, 1);
        wait_idle("R8");
        check(ctl_word == model, "R8", "word after hand-over", ctl_word, model);
        check_period(4'd7, "R8");
    endtask

    task automatic t_glitch();
        check(min_w >= 2.0 - 0.05, "R9", "shortest clk_out phase x100ps",
              longint'(min_w * 10.0), 20);
    endtask

    initial begin
        t_reset();
        t_request(4'd1);
        t_request(4'd2);
        t_request(4'd4);
        t_request(4'd5);
        t_request(4'd6);
        t_request(4'd7);
        t_request(4'd8);
        t_request(4'd0);
        t_request(4'd9);
        t_request(4'd15);
        t_ignore_busy();
        t_request(4'd2);
        t_glitch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule